// File: doc/BRIEF.md
# Inverted Page Table Lookup

This block translates a virtual address into a physical address using a table with one entry per physical frame. Each entry holds a process identifier, a virtual page number and a valid flag. A lookup presents a process identifier, a page number and a page offset. The block compares the pair against every entry in the same cycle. When a valid entry matches, that entry's position is the physical frame number. The frame number followed by the offset forms the physical address.

When no valid entry matches, the block reports a page fault so that the surrounding logic can trap. A separate write port lets software place a mapping at a chosen frame or clear one. The table grows with the number of physical frames, not with the size of the virtual space. Only the index of the match is turned into an address; no frame number is stored in the entry.

The default build has 16 frames, 8-bit process identifiers, 20-bit page numbers and 12-bit offsets, which gives 4 KB pages. The answer is registered and appears one cycle after the request.

Top module: `ipt_lookup`

## Requirements
- R1: After reset every entry is invalid and rsp_valid is low. A lookup made then reports a fault, whatever pair it presents.
- R2: rsp_valid is high in exactly the cycle after a cycle with lk_req high. While rsp_valid is low, rsp_hit, rsp_fault and rsp_multi are all low.
- R3: A lookup whose process ID and page number both equal those of a valid entry reports rsp_hit=1. rsp_frame then gives the index of that entry (0 to FRAMES-1).
- R4: On a hit, rsp_paddr equals the frame index in the upper bits followed by the lookup offset in the low OFF_W bits.
- R5: An entry whose page number matches but whose process ID differs does not match.
- R6: An entry with its valid bit clear never matches. Writing valid=0 to a frame removes that frame's mapping.
- R7: While rsp_valid is high, rsp_fault is the complement of rsp_hit.
- R8: When several valid entries match, the lowest index is reported and rsp_multi is set. rsp_multi is low on a lookup that has a single match.
- R9: A lookup in the same cycle as a write sees the table as it was before the write. The next lookup sees the written entry.
- R10: Writing a new pair to a frame replaces its old pair. The old pair no longer hits at that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| lk_req | input | 1 | Lookup request strobe |
| lk_pid | input | PID_W | Process identifier of the lookup |
| lk_vpn | input | VPN_W | Virtual page number of the lookup |
| lk_off | input | OFF_W | Page offset of the lookup |
| wr_en | input | 1 | Table write strobe |
| wr_frame | input | FRAME_W | Frame whose entry is written |
| wr_pid | input | PID_W | Process identifier written |
| wr_vpn | input | VPN_W | Page number written |
| wr_valid | input | 1 | Valid bit written; 0 clears the mapping |
| rsp_valid | output | 1 | Result valid, one cycle after lk_req |
| rsp_hit | output | 1 | A valid entry matched |
| rsp_fault | output | 1 | No valid entry matched (page fault) |
| rsp_multi | output | 1 | More than one valid entry matched |
| rsp_frame | output | FRAME_W | Index of the chosen matching entry |
| rsp_paddr | output | FRAME_W+OFF_W | Physical address: frame then offset |

## Verification
The bench uses pairs that share a page number but differ in process ID. A design that compares only the page would hit where it should fault. It places one pair in two frames: a design with the wrong priority order returns frame 9 instead of frame 2, and one without a duplicate check leaves rsp_multi low. It writes and looks up in the same cycle, which catches a write that bypasses into the lookup early. It also catches a lookup that stays stale one cycle too long. It also clears and rewrites frames, so a design that ignores the valid bit or keeps the old pair alive reports a false hit. The extreme frames 0 and 15 with all-ones fields expose a truncated index or a misplaced offset.

// File: rtl/ipt_pkg.sv
package ipt_pkg;
  localparam int unsigned DEF_FRAMES = 16;
  localparam int unsigned DEF_PID_W  = 8;
  localparam int unsigned DEF_VPN_W  = 20;
  localparam int unsigned DEF_OFF_W  = 12;

  typedef struct packed {
    logic hit;
    logic fault;
    logic multi;
  } ipt_flags_t;
endpackage

// File: rtl/ipt_rst_sync.sv
module ipt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/ipt_entry_store.sv
module ipt_entry_store #(
  parameter int unsigned FRAMES  = 16,
  parameter int unsigned PID_W   = 8,
  parameter int unsigned VPN_W   = 20,
  parameter int unsigned FRAME_W = (FRAMES > 1) ? $clog2(FRAMES) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [FRAME_W-1:0]             wr_frame,
  input  logic [PID_W-1:0]               wr_pid,
  input  logic [VPN_W-1:0]               wr_vpn,
  input  logic                           wr_valid,
  output logic [FRAMES-1:0]              ent_valid,
  output logic [FRAMES-1:0][PID_W-1:0]   ent_pid,
  output logic [FRAMES-1:0][VPN_W-1:0]   ent_vpn
);
  for (genvar f = 0; f < FRAMES; f++) begin : g_ent
    logic             sel;
    logic             valid_d, valid_q;
    logic [PID_W-1:0] pid_q;
    logic [VPN_W-1:0] vpn_q;

    assign sel = wr_en && (wr_frame == FRAME_W'(f));

    always_comb begin
      valid_d = valid_q;
      if (sel) valid_d = wr_valid;
    end

    // Only the valid bit is reset; the tag fields load under enable.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) valid_q <= 1'b0;
      else        valid_q <= valid_d;
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        pid_q <= wr_pid;
        vpn_q <= wr_vpn;
      end
    end

    assign ent_valid[f] = valid_q;
    assign ent_pid[f]   = pid_q;
    assign ent_vpn[f]   = vpn_q;
  end
endmodule

// File: rtl/ipt_match.sv
module ipt_match #(
  parameter int unsigned FRAMES = 16,
  parameter int unsigned PID_W  = 8,
  parameter int unsigned VPN_W  = 20
) (
  input  logic [FRAMES-1:0]            ent_valid,
  input  logic [FRAMES-1:0][PID_W-1:0] ent_pid,
  input  logic [FRAMES-1:0][VPN_W-1:0] ent_vpn,
  input  logic [PID_W-1:0]             key_pid,
  input  logic [VPN_W-1:0]             key_vpn,
  output logic [FRAMES-1:0]            match_vec
);
  for (genvar f = 0; f < FRAMES; f++) begin : g_cmp
    logic pid_eq, vpn_eq;
    assign pid_eq       = (ent_pid[f] == key_pid);
    assign vpn_eq       = (ent_vpn[f] == key_vpn);
    assign match_vec[f] = ent_valid[f] && pid_eq && vpn_eq;
  end
endmodule

// File: rtl/ipt_prio_pick.sv
module ipt_prio_pick #(
  parameter int unsigned FRAMES  = 16,
  parameter int unsigned FRAME_W = (FRAMES > 1) ? $clog2(FRAMES) : 1
) (
  input  logic [FRAMES-1:0]  match_vec,
  output logic               any_hit,
  output logic               multi_hit,
  output logic [FRAME_W-1:0] pick_idx
);
  logic [FRAMES-1:0] rest_vec;

  assign any_hit   = |match_vec;
  assign rest_vec  = match_vec & (match_vec - FRAMES'(1));
  assign multi_hit = |rest_vec;

  // Scan from the top down so the lowest set index is written last.
  always_comb begin
    pick_idx = '0;
    for (int i = FRAMES - 1; i >= 0; i--) begin
      if (match_vec[i]) pick_idx = FRAME_W'(i);
    end
  end
endmodule

// File: rtl/ipt_lookup.sv
module ipt_lookup
  import ipt_pkg::*;
#(
  parameter int unsigned FRAMES  = DEF_FRAMES,
  parameter int unsigned PID_W   = DEF_PID_W,
  parameter int unsigned VPN_W   = DEF_VPN_W,
  parameter int unsigned OFF_W   = DEF_OFF_W,
  parameter int unsigned FRAME_W = (FRAMES > 1) ? $clog2(FRAMES) : 1,
  parameter int unsigned PA_W    = FRAME_W + OFF_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lk_req,
  input  logic [PID_W-1:0]   lk_pid,
  input  logic [VPN_W-1:0]   lk_vpn,
  input  logic [OFF_W-1:0]   lk_off,
  input  logic               wr_en,
  input  logic [FRAME_W-1:0] wr_frame,
  input  logic [PID_W-1:0]   wr_pid,
  input  logic [VPN_W-1:0]   wr_vpn,
  input  logic               wr_valid,
  output logic               rsp_valid,
  output logic               rsp_hit,
  output logic               rsp_fault,
  output logic               rsp_multi,
  output logic [FRAME_W-1:0] rsp_frame,
  output logic [PA_W-1:0]    rsp_paddr
);
  logic                           rst_sync_n;
  logic [FRAMES-1:0]              ent_valid;
  logic [FRAMES-1:0][PID_W-1:0]   ent_pid;
  logic [FRAMES-1:0][VPN_W-1:0]   ent_vpn;
  logic [FRAMES-1:0]              match_vec;
  logic                           any_hit, multi_hit;
  logic [FRAME_W-1:0]             pick_idx;

  ipt_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ipt_entry_store #(
    .FRAMES(FRAMES), .PID_W(PID_W), .VPN_W(VPN_W), .FRAME_W(FRAME_W)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en     (wr_en),
    .wr_frame  (wr_frame),
    .wr_pid    (wr_pid),
    .wr_vpn    (wr_vpn),
    .wr_valid  (wr_valid),
    .ent_valid (ent_valid),
    .ent_pid   (ent_pid),
    .ent_vpn   (ent_vpn)
  );

  ipt_match #(
    .FRAMES(FRAMES), .PID_W(PID_W), .VPN_W(VPN_W)
  ) u_match (
    .ent_valid (ent_valid),
    .ent_pid   (ent_pid),
    .ent_vpn   (ent_vpn),
    .key_pid   (lk_pid),
    .key_vpn   (lk_vpn),
    .match_vec (match_vec)
  );

  ipt_prio_pick #(
    .FRAMES(FRAMES), .FRAME_W(FRAME_W)
  ) u_pick (
    .match_vec (match_vec),
    .any_hit   (any_hit),
    .multi_hit (multi_hit),
    .pick_idx  (pick_idx)
  );

  // Result registers
  ipt_flags_t         flags_d, flags_q;
  logic               vld_d, vld_q;
  logic               addr_en;
  logic [FRAME_W-1:0] frame_d, frame_q;
  logic [OFF_W-1:0]   off_q;

  always_comb begin
    vld_d   = lk_req;
    addr_en = lk_req;
    flags_d = '0;
    frame_d = '0;
    if (lk_req) begin
      flags_d.hit   = any_hit;
      flags_d.fault = !any_hit;
      flags_d.multi = multi_hit;
      frame_d       = any_hit ? pick_idx : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vld_q   <= 1'b0;
      flags_q <= '0;
    end else begin
      vld_q   <= vld_d;
      flags_q <= flags_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      frame_q <= '0;
      off_q   <= '0;
    end else if (addr_en) begin
      frame_q <= frame_d;
      off_q   <= lk_off;
    end
  end

  assign rsp_valid = vld_q;
  assign rsp_hit   = flags_q.hit;
  assign rsp_fault = flags_q.fault;
  assign rsp_multi = flags_q.multi;
  assign rsp_frame = frame_q;
  assign rsp_paddr = {frame_q, off_q};
endmodule

// File: rtl/ipt_lookup_chk.sv
module ipt_lookup_chk #(
  parameter int unsigned PID_W   = 8,
  parameter int unsigned VPN_W   = 20,
  parameter int unsigned OFF_W   = 12,
  parameter int unsigned FRAME_W = 4,
  parameter int unsigned PA_W    = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lk_req,
  input logic [PID_W-1:0]   lk_pid,
  input logic [VPN_W-1:0]   lk_vpn,
  input logic [OFF_W-1:0]   lk_off,
  input logic               wr_en,
  input logic [PID_W-1:0]   wr_pid,
  input logic [VPN_W-1:0]   wr_vpn,
  input logic               wr_valid,
  input logic               rsp_valid,
  input logic               rsp_hit,
  input logic               rsp_fault,
  input logic               rsp_multi,
  input logic [PA_W-1:0]    rsp_paddr
);
  logic             wseen_q;
  logic [PID_W-1:0] wpid_q;
  logic [VPN_W-1:0] wvpn_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wseen_q <= 1'b0;
      wpid_q  <= '0;
      wvpn_q  <= '0;
    end else begin
      wseen_q <= wr_en && wr_valid;
      wpid_q  <= wr_pid;
      wvpn_q  <= wr_vpn;
    end
  end

  p_rsp_after_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> rsp_valid);
  p_no_rsp_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |=> !rsp_valid);
  p_flags_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !(rsp_hit || rsp_fault || rsp_multi));
  p_hit_xor_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_hit != rsp_fault));
  p_multi_is_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_multi |-> rsp_hit);
  p_offset_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> (rsp_paddr[OFF_W-1:0] == $past(lk_off)));
  p_fresh_write_hits_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wseen_q && lk_req && lk_pid == wpid_q && lk_vpn == wvpn_q) |=> rsp_hit);
endmodule

bind ipt_lookup ipt_lookup_chk #(
  .PID_W(PID_W), .VPN_W(VPN_W), .OFF_W(OFF_W), .FRAME_W(FRAME_W), .PA_W(PA_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .lk_req    (lk_req),
  .lk_pid    (lk_pid),
  .lk_vpn    (lk_vpn),
  .lk_off    (lk_off),
  .wr_en     (wr_en),
  .wr_pid    (wr_pid),
  .wr_vpn    (wr_vpn),
  .wr_valid  (wr_valid),
  .rsp_valid (rsp_valid),
  .rsp_hit   (rsp_hit),
  .rsp_fault (rsp_fault),
  .rsp_multi (rsp_multi),
  .rsp_paddr (rsp_paddr)
);

// File: tb/sim_ipt_lookup.sv
`timescale 1ns/1ps
module sim_ipt_lookup;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        lk_req;
  logic [7:0]  lk_pid;
  logic [19:0] lk_vpn;
  logic [11:0] lk_off;
  logic        wr_en;
  logic [3:0]  wr_frame;
  logic [7:0]  wr_pid;
  logic [19:0] wr_vpn;
  logic        wr_valid;
  logic        rsp_valid, rsp_hit, rsp_fault, rsp_multi;
  logic [3:0]  rsp_frame;
  logic [15:0] rsp_paddr;

  int checks = 0;
  int fails  = 0;
  logic g_valid, g_hit, g_fault, g_multi;
  logic [3:0]  g_frame;
  logic [15:0] g_paddr;

  always #2 clk = ~clk;

  ipt_lookup u0 (
    .clk(clk), .rst_n(rst_n),
    .lk_req(lk_req), .lk_pid(lk_pid), .lk_vpn(lk_vpn), .lk_off(lk_off),
    .wr_en(wr_en), .wr_frame(wr_frame), .wr_pid(wr_pid), .wr_vpn(wr_vpn),
    .wr_valid(wr_valid),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault),
    .rsp_multi(rsp_multi), .rsp_frame(rsp_frame), .rsp_paddr(rsp_paddr)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic sample();
    g_valid = rsp_valid; g_hit = rsp_hit; g_fault = rsp_fault;
    g_multi = rsp_multi; g_frame = rsp_frame; g_paddr = rsp_paddr;
  endtask

  task automatic wr(input logic [3:0] f, input logic [7:0] p,
                    input logic [19:0] v, input logic val);
    @(negedge clk);
    wr_en = 1'b1; wr_frame = f; wr_pid = p; wr_vpn = v; wr_valid = val;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic look(input logic [7:0] p, input logic [19:0] v,
                      input logic [11:0] o);
    @(negedge clk);
    lk_req = 1'b1; lk_pid = p; lk_vpn = v; lk_off = o;
    @(negedge clk);
    lk_req = 1'b0;
    sample();
  endtask

  task automatic t_reset();
    check("R1", "rsp_valid after reset", 32'(rsp_valid), 32'd0);
    look(8'h00, 20'h00000, 12'h000);
    check("R1", "fault on empty table", 32'(g_fault), 32'd1);
    check("R1", "no hit on empty table", 32'(g_hit), 32'd0);
  endtask

  task automatic t_basic();
    wr(4'd5, 8'h03, 20'h12345, 1'b1);
    look(8'h03, 20'h12345, 12'hABC);
    check("R3", "hit", 32'(g_hit), 32'd1);
    check("R3", "frame", 32'(g_frame), 32'd5);
    check("R4", "paddr", 32'(g_paddr), 32'h5ABC);
    check("R7", "fault low on hit", 32'(g_fault), 32'd0);
    check("R8", "multi low on single hit", 32'(g_multi), 32'd0);
    wr(4'd15, 8'hFF, 20'hFFFFF, 1'b1);
    look(8'hFF, 20'hFFFFF, 12'hFFF);
    check("R4", "paddr top frame", 32'(g_paddr), 32'hFFFF);
    wr(4'd0, 8'h00, 20'h00000, 1'b1);
    look(8'h00, 20'h00000, 12'h123);
    check("R3", "frame zero hit", 32'(g_hit), 32'd1);
    check("R4", "paddr frame zero", 32'(g_paddr), 32'h0123);
  endtask

  task automatic t_pid_mismatch();
    look(8'h04, 20'h12345, 12'h000);
    check("R5", "other pid misses", 32'(g_hit), 32'd0);
    check("R7", "fault on miss", 32'(g_fault), 32'd1);
  endtask

  task automatic t_pipe();
    @(negedge clk);
    lk_req = 1'b1; lk_pid = 8'h03; lk_vpn = 20'h12345; lk_off = 12'h001;
    @(negedge clk);
    sample();
    lk_pid = 8'h09; lk_vpn = 20'h55555; lk_off = 12'h002;
    check("R2", "first valid", 32'(g_valid), 32'd1);
    check("R3", "first hit", 32'(g_hit), 32'd1);
    @(negedge clk);
    sample();
    lk_req = 1'b0;
    check("R2", "second valid", 32'(g_valid), 32'd1);
    check("R7", "second fault", 32'(g_fault), 32'd1);
    @(negedge clk);
    sample();
    check("R2", "idle valid low", 32'(g_valid), 32'd0);
    check("R2", "idle flags low", 32'({g_hit, g_fault, g_multi}), 32'd0);
  endtask

  task automatic t_invalidate();
    wr(4'd5, 8'h03, 20'h12345, 1'b0);
    look(8'h03, 20'h12345, 12'h000);
    check("R6", "cleared entry misses", 32'(g_fault), 32'd1);
  endtask

  task automatic t_multi();
    wr(4'd9, 8'h21, 20'h0BEEF, 1'b1);
    wr(4'd2, 8'h21, 20'h0BEEF, 1'b1);
    look(8'h21, 20'h0BEEF, 12'h010);
    check("R8", "lowest frame chosen", 32'(g_frame), 32'd2);
    check("R8", "multi flag", 32'(g_multi), 32'd1);
    check("R8", "hit on multi", 32'(g_hit), 32'd1);
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    wr_en = 1'b1; wr_frame = 4'd7; wr_pid = 8'h06; wr_vpn = 20'hABCDE; wr_valid = 1'b1;
    lk_req = 1'b1; lk_pid = 8'h06; lk_vpn = 20'hABCDE; lk_off = 12'h044;
    @(negedge clk);
    sample();
    wr_en = 1'b0;
    check("R9", "same-cycle lookup sees old table", 32'(g_fault), 32'd1);
    @(negedge clk);
    sample();
    lk_req = 1'b0;
    check("R9", "next lookup hits", 32'(g_hit), 32'd1);
    check("R9", "next lookup frame", 32'(g_frame), 32'd7);
  endtask

  task automatic t_replace();
    wr(4'd7, 8'h06, 20'h11111, 1'b1);
    look(8'h06, 20'hABCDE, 12'h000);
    check("R10", "old pair gone", 32'(g_fault), 32'd1);
    look(8'h06, 20'h11111, 12'h777);
    check("R10", "new pair frame", 32'(g_frame), 32'd7);
    check("R10", "new pair paddr", 32'(g_paddr), 32'h7777);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; lk_req = 1'b0; lk_pid = '0; lk_vpn = '0; lk_off = '0;
    wr_en = 1'b0; wr_frame = '0; wr_pid = '0; wr_vpn = '0; wr_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_basic();
    t_pid_mismatch();
    t_pipe();
    t_invalidate();
    t_multi();
    t_same_cycle();
    t_replace();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule